// File: doc/BRIEF.md
# DRAM Bank Machine Pool

This block is a pool of identical bank machines inside a DRAM memory controller. Each user request carries a read/write flag, a bank, a row and a column. An accepted request goes to one idle machine. That machine requests the row commands (activate, precharge) and the column command (read or write) the request needs. When the request is done, the machine returns to the idle pool. A machine belongs to a request, not to a physical bank, so the pool can hold fewer machines than the DRAM has banks.

Requests to a bank that already has a busy machine are linked behind the youngest machine on that bank. If the new request targets the same row and that machine has not yet been granted its precharge, the row stays open. The new machine skips its activate, and the older machine skips its precharge. A request with same-row neighbours on both sides issues only its column command. A request to a different row waits until the older machine's precharge and precharge-to-activate time are complete, then activates its own row.

Each machine raises its own row-command and column-command requests towards a downstream arbiter and acts on that arbiter's per-machine grants. Simple down-counters hold each command back until its DRAM timing minimum is met.

Top module: `bank_machine_pool`

## Requirements
- R1: `req_ready` is high exactly when at least one machine is idle. After reset it is high, and no row or column request is raised.
- R2: An accepted request is taken by the lowest-numbered idle machine, and that machine's `bm_*` outputs show the request's fields.
- R3: A request to a bank with no busy machine produces exactly one activate, then one column command, then one precharge, and the machine then returns to idle.
- R4: `row_is_pre` is 0 for an activate and 1 for a precharge. A command is issued in the cycle where request and grant of the same machine are both high. `bm_write` is 1 for a write and 0 for a read.
- R5: A column command to a bank comes at least `T_RCD` cycles after the activate of that bank. For an isolated request with immediate grants, the gap is exactly `T_RCD`.
- R6: A precharge to a bank comes at least `T_RAS` cycles after that bank's activate.
- R7: An activate to a bank comes at least `T_RP` cycles after that bank's previous precharge.
- R8: A request to the same bank and row as the youngest busy machine on that bank is linked to it, as long as that machine has not been granted its precharge. The new machine issues no activate and the older machine issues no precharge. A run of three such requests uses one activate and one precharge in total.
- R9: A request to the same bank but a different row waits for the older machine's precharge to complete, then issues its own activate.
- R10: Column commands to a bank are issued in acceptance order. At no time do two machines raise column requests for the same bank.
- R11: No activate is issued to a bank whose row is open, and no precharge to a bank whose row is closed.
- R12: With every machine busy, `req_ready` is low and a pending request waits. Requests may target any of the 2^`BANK_W` banks, even though there are fewer machines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | A machine is free to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bank | input | BANK_W | Target bank |
| req_row | input | ROW_W | Target row |
| req_col | input | COL_W | Target column |
| row_req | output | NUM_BM | Per-machine row-command request |
| row_is_pre | output | NUM_BM | Per-machine row command kind, 1 = precharge |
| row_gnt | input | NUM_BM | Per-machine row-command grant |
| col_req | output | NUM_BM | Per-machine column-command request |
| col_gnt | input | NUM_BM | Per-machine column-command grant |
| bm_write | output | NUM_BM | Per-machine write flag |
| bm_bank | output | NUM_BM*BANK_W | Per-machine bank, machine i at slice i |
| bm_row | output | NUM_BM*ROW_W | Per-machine row |
| bm_col | output | NUM_BM*COL_W | Per-machine column |

## Verification
Two events can land in the same cycle: a new same-row request being linked behind a machine, and that machine's own column grant or precharge request. The bench sends same-row requests on consecutive cycles while the arbiter grants at once, so the link is made while the older machine is still activating or is firing its column command. The outcome is judged by counting activates, column commands and precharges per scenario, and by checking the scoreboard order of the column commands. The open-row and timing checks in the checker show that no precharge was lost or doubled.

// File: rtl/bmp_pkg.sv
package bmp_pkg;
  typedef enum logic [2:0] {
    BM_IDLE,
    BM_WAITP,
    BM_ACT,
    BM_CHAIN,
    BM_COL,
    BM_PRE,
    BM_RP
  } bm_state_e;
endpackage

// File: rtl/bmp_prio.sv
module bmp_prio #(
  parameter int N = 4
) (
  input  logic [N-1:0]                    req,
  output logic                            any,
  output logic [((N>1)?$clog2(N):1)-1:0]  idx
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end

  assign any = |req;
endmodule

// File: rtl/bmp_machine.sv
module bmp_machine
  import bmp_pkg::*;
#(
  parameter int N      = 4,
  parameter int IW     = 2,
  parameter int BANK_W = 3,
  parameter int ROW_W  = 14,
  parameter int COL_W  = 10,
  parameter int T_RCD  = 3,
  parameter int T_RAS  = 8,
  parameter int T_RP   = 3,
  parameter int TW     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc,
  input  logic              ld_write,
  input  logic [BANK_W-1:0] ld_bank,
  input  logic [ROW_W-1:0]  ld_row,
  input  logic [COL_W-1:0]  ld_col,
  input  logic              ld_has_pred,
  input  logic              ld_hit,
  input  logic [IW-1:0]     ld_pred_idx,
  input  logic              ld_pred_ok,
  input  logic [TW-1:0]     ld_ras,
  input  logic              succ_set,
  input  logic              succ_hit,
  input  logic              row_gnt,
  input  logic              col_gnt,
  input  logic [N-1:0]      col_fire_vec,
  input  logic [N-1:0]      rel_vec,
  input  logic [N*TW-1:0]   ras_vec,
  output logic              busy,
  output logic              tail_ok,
  output logic              past_col,
  output logic              has_succ,
  output logic              row_req,
  output logic              row_pre,
  output logic              col_req,
  output logic              col_fire,
  output logic              rel,
  output logic [TW-1:0]     ras_o,
  output logic              write_o,
  output logic [BANK_W-1:0] bank_o,
  output logic [ROW_W-1:0]  row_o,
  output logic [COL_W-1:0]  col_o
);
  bm_state_e         st_q, st_d;
  logic [IW-1:0]     pred_q;
  logic              pok_q, pok_d;
  logic              sv_q, sh_q;
  logic [TW-1:0]     rcd_q, rcd_d, ras_q, ras_d, rp_q, rp_d;
  logic              row_fire, pred_evt, pred_go, hit_now;

  function automatic logic [TW-1:0] dec(input logic [TW-1:0] v);
    return (v == '0) ? '0 : v - 1'b1;
  endfunction

  assign row_req  = (st_q == BM_ACT) || (st_q == BM_PRE && ras_q == '0);
  assign row_pre  = (st_q == BM_PRE);
  assign col_req  = (st_q == BM_COL) && (rcd_q == '0);
  assign row_fire = row_req && row_gnt;
  assign col_fire = col_req && col_gnt;
  assign rel      = (st_q == BM_RP) && (rp_q == '0);
  assign busy     = (st_q != BM_IDLE);
  assign tail_ok  = busy && (st_q != BM_RP) && !(st_q == BM_PRE && row_fire);
  assign past_col = (st_q == BM_PRE);
  assign has_succ = sv_q;
  assign ras_o    = ras_q;

  assign pred_evt = ((st_q == BM_WAITP) && rel_vec[pred_q]) ||
                    ((st_q == BM_CHAIN) && col_fire_vec[pred_q]);
  assign pred_go  = pok_q || pred_evt;
  assign hit_now  = (sv_q && sh_q) || (succ_set && succ_hit);

  always_comb begin
    st_d  = st_q;
    rcd_d = dec(rcd_q);
    ras_d = dec(ras_q);
    rp_d  = dec(rp_q);
    pok_d = pok_q || pred_evt;
    case (st_q)
      BM_IDLE: if (alloc) begin
        st_d  = !ld_has_pred ? BM_ACT : (ld_hit ? BM_CHAIN : BM_WAITP);
        pok_d = ld_pred_ok;
        ras_d = ld_ras;
        rcd_d = '0;
      end
      BM_WAITP: if (pred_go) st_d = BM_ACT;
      BM_ACT: if (row_fire) begin
        st_d  = BM_COL;
        rcd_d = TW'(T_RCD - 1);
        ras_d = TW'(T_RAS - 1);
      end
      BM_CHAIN: begin
        if (!pok_q) ras_d = ras_vec[pred_q*TW +: TW];
        if (pred_go) st_d = BM_COL;
      end
      BM_COL: if (col_fire) st_d = hit_now ? BM_IDLE : BM_PRE;
      BM_PRE: begin
        if (row_fire) begin
          st_d = BM_RP;
          rp_d = TW'(T_RP - 1);
        end else if (hit_now) begin
          st_d = BM_IDLE;
        end
      end
      BM_RP: if (rp_q == '0) st_d = BM_IDLE;
      default: st_d = BM_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= BM_IDLE;
      pok_q <= 1'b0;
      rcd_q <= '0;
      ras_q <= '0;
      rp_q  <= '0;
    end else begin
      st_q  <= st_d;
      pok_q <= pok_d;
      rcd_q <= rcd_d;
      ras_q <= ras_d;
      rp_q  <= rp_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      write_o <= 1'b0;
      bank_o  <= '0;
      row_o   <= '0;
      col_o   <= '0;
      pred_q  <= '0;
    end else if (alloc) begin
      write_o <= ld_write;
      bank_o  <= ld_bank;
      row_o   <= ld_row;
      col_o   <= ld_col;
      pred_q  <= ld_pred_idx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sv_q <= 1'b0;
      sh_q <= 1'b0;
    end else if (alloc) begin
      sv_q <= 1'b0;
      sh_q <= 1'b0;
    end else if (succ_set) begin
      sv_q <= 1'b1;
      sh_q <= succ_hit;
    end
  end
endmodule

// File: rtl/bank_machine_pool.sv
module bank_machine_pool #(
  parameter int NUM_BM = 4,
  parameter int BANK_W = 3,
  parameter int ROW_W  = 14,
  parameter int COL_W  = 10,
  parameter int T_RCD  = 3,
  parameter int T_RAS  = 8,
  parameter int T_RP   = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic                      req_write,
  input  logic [BANK_W-1:0]         req_bank,
  input  logic [ROW_W-1:0]          req_row,
  input  logic [COL_W-1:0]          req_col,
  output logic [NUM_BM-1:0]         row_req,
  output logic [NUM_BM-1:0]         row_is_pre,
  input  logic [NUM_BM-1:0]         row_gnt,
  output logic [NUM_BM-1:0]         col_req,
  input  logic [NUM_BM-1:0]         col_gnt,
  output logic [NUM_BM-1:0]         bm_write,
  output logic [NUM_BM*BANK_W-1:0]  bm_bank,
  output logic [NUM_BM*ROW_W-1:0]   bm_row,
  output logic [NUM_BM*COL_W-1:0]   bm_col
);
  localparam int IW    = (NUM_BM > 1) ? $clog2(NUM_BM) : 1;
  localparam int T_M1  = (T_RCD > T_RAS) ? T_RCD : T_RAS;
  localparam int T_MAX = (T_M1 > T_RP) ? T_M1 : T_RP;
  localparam int TW    = $clog2(T_MAX + 1);

  logic [1:0]          rst_pipe;
  logic                rst_n_i;
  logic [NUM_BM-1:0]   busy, tail_ok, past_col, has_succ, col_fire, rel, cand;
  logic [NUM_BM*TW-1:0] ras_vec;
  logic [ROW_W-1:0]    m_row [NUM_BM];
  logic [IW-1:0]       head_idx, tail_idx;
  logic                head_any, tail_found, accept, hit, ld_pred_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_i = rst_pipe[1];

  bmp_prio #(.N(NUM_BM)) i_head (.req(~busy), .any(head_any), .idx(head_idx));
  bmp_prio #(.N(NUM_BM)) i_tail (.req(cand), .any(tail_found), .idx(tail_idx));

  assign req_ready  = head_any;
  assign accept     = req_valid && req_ready;
  assign hit        = tail_found && tail_ok[tail_idx] && (m_row[tail_idx] == req_row);
  assign ld_pred_ok = hit ? (col_fire[tail_idx] || past_col[tail_idx]) : rel[tail_idx];

  for (genvar i = 0; i < NUM_BM; i++) begin : g_bm
    assign cand[i] = busy[i] && !has_succ[i] &&
                     (bm_bank[i*BANK_W +: BANK_W] == req_bank);

    bmp_machine #(
      .N(NUM_BM), .IW(IW), .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W),
      .T_RCD(T_RCD), .T_RAS(T_RAS), .T_RP(T_RP), .TW(TW)
    ) i_machine (
      .clk          (clk),
      .rst_n        (rst_n_i),
      .alloc        (accept && (head_idx == IW'(i))),
      .ld_write     (req_write),
      .ld_bank      (req_bank),
      .ld_row       (req_row),
      .ld_col       (req_col),
      .ld_has_pred  (tail_found),
      .ld_hit       (hit),
      .ld_pred_idx  (tail_idx),
      .ld_pred_ok   (ld_pred_ok),
      .ld_ras       (ras_vec[tail_idx*TW +: TW]),
      .succ_set     (accept && tail_found && (tail_idx == IW'(i))),
      .succ_hit     (hit),
      .row_gnt      (row_gnt[i]),
      .col_gnt      (col_gnt[i]),
      .col_fire_vec (col_fire),
      .rel_vec      (rel),
      .ras_vec      (ras_vec),
      .busy         (busy[i]),
      .tail_ok      (tail_ok[i]),
      .past_col     (past_col[i]),
      .has_succ     (has_succ[i]),
      .row_req      (row_req[i]),
      .row_pre      (row_is_pre[i]),
      .col_req      (col_req[i]),
      .col_fire     (col_fire[i]),
      .rel          (rel[i]),
      .ras_o        (ras_vec[i*TW +: TW]),
      .write_o      (bm_write[i]),
      .bank_o       (bm_bank[i*BANK_W +: BANK_W]),
      .row_o        (m_row[i]),
      .col_o        (bm_col[i*COL_W +: COL_W])
    );

    assign bm_row[i*ROW_W +: ROW_W] = m_row[i];
  end
endmodule

// File: rtl/bmp_checker.sv
module bmp_checker #(
  parameter int NUM_BM = 4,
  parameter int BANK_W = 3,
  parameter int T_RCD  = 3,
  parameter int T_RAS  = 8,
  parameter int T_RP   = 3
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [NUM_BM-1:0]        row_req,
  input logic [NUM_BM-1:0]        row_is_pre,
  input logic [NUM_BM-1:0]        row_gnt,
  input logic [NUM_BM-1:0]        col_req,
  input logic [NUM_BM-1:0]        col_gnt,
  input logic [NUM_BM*BANK_W-1:0] bm_bank
);
  localparam int NB = 1 << BANK_W;

  logic [NB-1:0] act_on, pre_on, col_on, open_q;
  logic [7:0]    since_act [NB];
  logic [7:0]    since_pre [NB];

  always_comb begin
    act_on = '0;
    pre_on = '0;
    col_on = '0;
    for (int i = 0; i < NUM_BM; i++) begin
      for (int b = 0; b < NB; b++) begin
        if (bm_bank[i*BANK_W +: BANK_W] == BANK_W'(b)) begin
          if (row_req[i] && row_gnt[i] && !row_is_pre[i]) act_on[b] = 1'b1;
          if (row_req[i] && row_gnt[i] &&  row_is_pre[i]) pre_on[b] = 1'b1;
          if (col_req[i] && col_gnt[i])                   col_on[b] = 1'b1;
        end
      end
    end
  end

  for (genvar b = 0; b < NB; b++) begin : g_bank
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        open_q[b]    <= 1'b0;
        since_act[b] <= 8'hff;
        since_pre[b] <= 8'hff;
      end else begin
        if (act_on[b])      open_q[b] <= 1'b1;
        else if (pre_on[b]) open_q[b] <= 1'b0;
        since_act[b] <= act_on[b] ? 8'd1 : ((since_act[b] == 8'hff) ? 8'hff : since_act[b] + 8'd1);
        since_pre[b] <= pre_on[b] ? 8'd1 : ((since_pre[b] == 8'hff) ? 8'hff : since_pre[b] + 8'd1);
      end
    end

    a_r5_rcd: assert property (@(posedge clk) disable iff (!rst_n)
      col_on[b] |-> (since_act[b] >= 8'(T_RCD)));
    a_r6_ras: assert property (@(posedge clk) disable iff (!rst_n)
      pre_on[b] |-> (since_act[b] >= 8'(T_RAS)));
    a_r7_rp: assert property (@(posedge clk) disable iff (!rst_n)
      act_on[b] |-> (since_pre[b] >= 8'(T_RP)));
    a_r11_act_closed: assert property (@(posedge clk) disable iff (!rst_n)
      act_on[b] |-> !open_q[b]);
    a_r11_pre_open: assert property (@(posedge clk) disable iff (!rst_n)
      pre_on[b] |-> open_q[b]);
    a_r3_col_on_open: assert property (@(posedge clk) disable iff (!rst_n)
      col_on[b] |-> (open_q[b] && !pre_on[b]));
  end

  for (genvar i = 0; i < NUM_BM; i++) begin : g_pi
    for (genvar j = i + 1; j < NUM_BM; j++) begin : g_pj
      a_r10_one_col: assert property (@(posedge clk) disable iff (!rst_n)
        !(col_req[i] && col_req[j] &&
          (bm_bank[i*BANK_W +: BANK_W] == bm_bank[j*BANK_W +: BANK_W])));
    end
  end
endmodule

bind bank_machine_pool bmp_checker #(
  .NUM_BM(NUM_BM), .BANK_W(BANK_W), .T_RCD(T_RCD), .T_RAS(T_RAS), .T_RP(T_RP)
) i_bmp_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .row_req    (row_req),
  .row_is_pre (row_is_pre),
  .row_gnt    (row_gnt),
  .col_req    (col_req),
  .col_gnt    (col_gnt),
  .bm_bank    (bm_bank)
);

// File: tb/test_bank_machine_pool.sv
`timescale 1ns/1ps
module test_bank_machine_pool;
  localparam int NBM = 4, BW = 3, RW = 14, CW = 10;
  localparam int TRCD = 3, TRAS = 8, TRP = 3;
  localparam int NB = 1 << BW;

  typedef struct { logic w; logic [BW-1:0] b; logic [RW-1:0] r; logic [CW-1:0] c; } item_t;

  logic clk, rst_n, req_valid, req_ready, req_write, gnt_en;
  logic [BW-1:0] req_bank;
  logic [RW-1:0] req_row;
  logic [CW-1:0] req_col;
  logic [NBM-1:0] row_req, row_is_pre, row_gnt, col_req, col_gnt, bm_write;
  logic [NBM*BW-1:0] bm_bank;
  logic [NBM*RW-1:0] bm_row;
  logic [NBM*CW-1:0] bm_col;

  int n_tests, n_fail, cyc;
  int n_act, n_pre, n_col;
  int act_cyc [NB];
  int pre_cyc [NB];
  int rcd_gap [NB];
  int ras_gap [NB];
  int rp_gap  [NB];
  item_t exp_q[$];

  assign row_gnt = row_req & {NBM{gnt_en}};
  assign col_gnt = col_req & {NBM{gnt_en}};

  bank_machine_pool #(.NUM_BM(NBM), .BANK_W(BW), .ROW_W(RW), .COL_W(CW),
    .T_RCD(TRCD), .T_RAS(TRAS), .T_RP(TRP)) i_bank_machine_pool (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
    .row_req(row_req), .row_is_pre(row_is_pre), .row_gnt(row_gnt),
    .col_req(col_req), .col_gnt(col_gnt), .bm_write(bm_write),
    .bm_bank(bm_bank), .bm_row(bm_row), .bm_col(bm_col));

  initial clk = 1'b0;
  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(string tag, logic ok, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Monitor: counts commands, timing gaps, and scoreboards column commands
  always @(negedge clk) begin
    if (rst_n) begin
      for (int i = 0; i < NBM; i++) begin
        int b;
        b = int'(bm_bank[i*BW +: BW]);
        if (row_req[i] && row_gnt[i]) begin
          if (row_is_pre[i]) begin
            n_pre++; ras_gap[b] = cyc - act_cyc[b]; pre_cyc[b] = cyc;
          end else begin
            n_act++; rp_gap[b] = cyc - pre_cyc[b]; act_cyc[b] = cyc;
          end
        end
        if (col_req[i] && col_gnt[i]) begin
          int k;
          n_col++;
          rcd_gap[b] = cyc - act_cyc[b];
          k = -1;
          for (int q = 0; q < exp_q.size(); q++)
            if (k < 0 && int'(exp_q[q].b) == b) k = q;
          check("R10 column for unexpected bank", k >= 0, b, -1);
          if (k >= 0) begin
            check("R10 column order/row", bm_row[i*RW +: RW] == exp_q[k].r,
                  int'(bm_row[i*RW +: RW]), int'(exp_q[k].r));
            check("R4 column address", bm_col[i*CW +: CW] == exp_q[k].c,
                  int'(bm_col[i*CW +: CW]), int'(exp_q[k].c));
            check("R4 write flag", bm_write[i] == exp_q[k].w,
                  int'(bm_write[i]), int'(exp_q[k].w));
            exp_q.delete(k);
          end
        end
      end
    end
  end

  // Driver: called at a negedge, leaves at a negedge
  task automatic send(logic w, int b, int r, int c);
    item_t it;
    req_valid = 1'b1; req_write = w;
    req_bank = BW'(b); req_row = RW'(r); req_col = CW'(c);
    while (!req_ready) @(negedge clk);
    it.w = w; it.b = BW'(b); it.r = RW'(r); it.c = CW'(c);
    exp_q.push_back(it);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic drain();
    repeat (40) @(negedge clk);
  endtask

  initial begin
    cyc = 0;
    wait (cyc > 50000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 50000);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int a0, p0, c0;
    n_tests = 0; n_fail = 0; n_act = 0; n_pre = 0; n_col = 0;
    for (int b = 0; b < NB; b++) begin act_cyc[b] = -1000; pre_cyc[b] = -1000; end
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; gnt_en = 1'b1;
    req_bank = '0; req_row = '0; req_col = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1 ready after reset", req_ready == 1'b1, int'(req_ready), 1);
    check("R1 no requests after reset", (row_req | col_req) == '0, int'(row_req | col_req), 0);

    // R3/R5/R6 isolated request; R2 head is machine 0
    a0 = n_act; p0 = n_pre; c0 = n_col;
    send(1'b0, 1, 5, 7);
    check("R2 head machine 0 takes request", row_req == 4'b0001, int'(row_req), 1);
    drain();
    check("R3 isolated activates", n_act - a0 == 1, n_act - a0, 1);
    check("R3 isolated columns", n_col - c0 == 1, n_col - c0, 1);
    check("R3 isolated precharges", n_pre - p0 == 1, n_pre - p0, 1);
    check("R5 activate-to-column gap", rcd_gap[1] == TRCD, rcd_gap[1], TRCD);
    check("R6 activate-to-precharge gap", ras_gap[1] >= TRAS, ras_gap[1], TRAS);

    // R8 two back-to-back same-row requests
    a0 = n_act; p0 = n_pre; c0 = n_col;
    send(1'b1, 2, 9, 1);
    send(1'b0, 2, 9, 2);
    drain();
    check("R8 pair activates", n_act - a0 == 1, n_act - a0, 1);
    check("R8 pair precharges", n_pre - p0 == 1, n_pre - p0, 1);
    check("R8 pair columns", n_col - c0 == 2, n_col - c0, 2);

    // R8 chain of three same-row requests
    a0 = n_act; p0 = n_pre; c0 = n_col;
    send(1'b0, 6, 33, 10);
    send(1'b1, 6, 33, 11);
    send(1'b0, 6, 33, 12);
    drain();
    check("R8 triple activates", n_act - a0 == 1, n_act - a0, 1);
    check("R8 triple precharges", n_pre - p0 == 1, n_pre - p0, 1);
    check("R8 triple columns", n_col - c0 == 3, n_col - c0, 3);

    // R9/R7 same bank, different row
    a0 = n_act; p0 = n_pre;
    send(1'b0, 3, 1, 20);
    send(1'b1, 3, 2, 21);
    drain();
    check("R9 row-miss activates", n_act - a0 == 2, n_act - a0, 2);
    check("R9 row-miss precharges", n_pre - p0 == 2, n_pre - p0, 2);
    check("R7 precharge-to-activate gap", rp_gap[3] >= TRP, rp_gap[3], TRP);

    // R12 pool exhaustion with grants withheld
    gnt_en = 1'b0;
    send(1'b0, 4, 40, 1);
    send(1'b0, 5, 50, 2);
    send(1'b1, 6, 60, 3);
    send(1'b1, 7, 70, 4);
    check("R2 machines taken in order", row_req == 4'b1111, int'(row_req), 15);
    check("R12 ready low when pool full", req_ready == 1'b0, int'(req_ready), 0);
    gnt_en = 1'b1;
    a0 = n_act; c0 = n_col;
    send(1'b0, 4, 41, 5);
    drain();
    check("R12 waiting request served", n_col - c0 == 5, n_col - c0, 5);
    check("R12 activates after full pool", n_act - a0 == 5, n_act - a0, 5);

    // R4/R10 mixed pattern
    a0 = n_act; p0 = n_pre;
    send(1'b1, 0, 3, 1);
    send(1'b1, 0, 3, 2);
    send(1'b0, 0, 4, 3);
    send(1'b0, 1, 3, 4);
    drain();
    check("R10 mixed activates", n_act - a0 == 3, n_act - a0, 3);
    check("R10 mixed precharges", n_pre - p0 == 3, n_pre - p0, 3);
    check("R10 scoreboard empty", exp_q.size() == 0, exp_q.size(), 0);
    check("R1 idle at end", req_ready == 1'b1 && (row_req | col_req) == '0,
          int'(row_req | col_req), 0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule